// File: doc/BRIEF.md
# Dual-Host DMA Request FIFO Window

This block is a small register window that two 16-bit hosts share. A producer host programs a DMA source address, a destination address and a transfer length, and streams data words into a FIFO data register. A consumer host, usually its DMA engine, reads the same configuration registers back and drains the data words. The FIFO is not a ring. It is two four-word blocks, A and B, and the blocks change roles only as whole blocks. The producer fills one block while the consumer drains the other. When a filled block becomes readable, a one-cycle data-available pulse is sent toward the consumer's DMA engine.

Each port has its own select, write enable, 3-bit word offset and write data. Read data is combinational within the cycle, and all state changes on the rising clock edge. Two sticky flags record lost producer words and consumer reads from a block that was not full. Only reset clears them.

Top module: `dreq_fifo_window`

## Requirements
- R1: After reset, every register reads 0 from both ports, data_avail_o, overflow_o and underrun_o are 0, both blocks are empty, and writer and reader both point at block A.
- R2: Writes are masked. Offset 0 (source high) keeps bits 7:0. Offset 1 (source low) keeps bits 15:1 and clears bit 0. Offset 2 (destination high) keeps bits 7:0. Offset 3 (destination low) keeps all 16 bits. Offset 4 (length) keeps bits 15:2 and clears bits 1:0.
- R3: Either port may write offsets 0 to 4 and read back the stored masked value. Offsets 6 and 7 read 0 and ignore writes. If both ports write the same offset in one cycle, the producer's value is stored.
- R4: A producer read of offset 5 (FIFO data) returns 0xFFFF and changes no state.
- R5: A consumer write to offset 5 is ignored and leaves the FIFO contents and pointers unchanged.
- R6: Words written by the producer to offset 5 come out of consumer reads of offset 5 in the same order, across block swaps.
- R7: The fourth word written into a block marks that block full. If the other block is not full, the writer moves to the other block, the reader moves to the block just filled, and data_avail_o is high for exactly the one cycle after that edge.
- R8: A producer write to a block that is already full is dropped, and overflow_o sets and stays set until reset.
- R9: A consumer read of offset 5 from a block that is not full sets underrun_o, which stays set until reset. The read index still advances.
- R10: The fourth consumer read of a block clears that block's full flag. If the other block is full, the reader moves to it and the writer moves to the block just emptied.
- R11: When a consumer read of offset 5 and a producer write of offset 5 happen in the same cycle, the read takes effect first and the write then sees the updated flags and pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p_sel_i | input | 1 | Producer port select |
| p_we_i | input | 1 | Producer write enable |
| p_addr_i | input | 3 | Producer word offset |
| p_wdata_i | input | 16 | Producer write data |
| p_rdata_o | output | 16 | Producer read data (0 when not selected) |
| c_sel_i | input | 1 | Consumer port select |
| c_we_i | input | 1 | Consumer write enable |
| c_addr_i | input | 3 | Consumer word offset |
| c_wdata_i | input | 16 | Consumer write data |
| c_rdata_o | output | 16 | Consumer read data (0 when not selected) |
| data_avail_o | output | 1 | One-cycle pulse when a filled block is handed to the reader |
| overflow_o | output | 1 | Sticky: a producer word was dropped |
| underrun_o | output | 1 | Sticky: the consumer read a block that was not full |

## Verification
The collision that matters is the producer's fourth word completing one block in the same cycle as the consumer's fourth read completing the other block. Because the read is applied first, the writer finds the drained block empty, hands over the block it just filled, and raises data_avail_o. The bench sets this up by filling block A, writing three words into B and reading three words from A. It then issues both final accesses in one cycle, checks for the pulse, and checks that the next four consumer reads return B's words in order. The same step-by-step model also judges the register-write collision, where both ports write offset 3 in the same cycle.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int unsigned DW   = 16;
  localparam int unsigned AW   = 3;
  localparam int unsigned NREG = 5;

  localparam logic [AW-1:0] OFF_SRC_HI = 3'd0;
  localparam logic [AW-1:0] OFF_SRC_LO = 3'd1;
  localparam logic [AW-1:0] OFF_DST_HI = 3'd2;
  localparam logic [AW-1:0] OFF_DST_LO = 3'd3;
  localparam logic [AW-1:0] OFF_LEN    = 3'd4;
  localparam logic [AW-1:0] OFF_DATA   = 3'd5;

  localparam logic [DW-1:0] PROD_DATA_RD = 16'hFFFF;

  function automatic logic [DW-1:0] reg_mask(input int idx);
    case (idx)
      0:       return 16'h00FF;
      1:       return 16'hFFFE;
      2:       return 16'h00FF;
      3:       return 16'hFFFF;
      4:       return 16'hFFFC;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/dreq_cfg_regs.sv
module dreq_cfg_regs
  import dreq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          p_wen_i,
  input  logic [AW-1:0] p_addr_i,
  input  logic [DW-1:0] p_wdata_i,
  input  logic          c_wen_i,
  input  logic [AW-1:0] c_addr_i,
  input  logic [DW-1:0] c_wdata_i,
  output logic [DW-1:0] p_rd_o,
  output logic [DW-1:0] c_rd_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    localparam logic [AW-1:0] OFF  = AW'(gi);
    localparam logic [DW-1:0] MASK = reg_mask(gi);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[gi] <= '0;
      else if (p_wen_i && p_addr_i == OFF)  regs_q[gi] <= p_wdata_i & MASK;
      else if (c_wen_i && c_addr_i == OFF)  regs_q[gi] <= c_wdata_i & MASK;
    end
  end

  function automatic logic [DW-1:0] rd_sel(input logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < NREG; i++)
      if (a == AW'(i)) r = regs_q[i];
    return r;
  endfunction

  assign p_rd_o = rd_sel(p_addr_i);
  assign c_rd_o = rd_sel(c_addr_i);

  // R3
  prod_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_wen_i && p_addr_i == OFF_DST_LO |=> regs_q[3] == $past(p_wdata_i));

  // R2
  len_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_wen_i && c_addr_i == OFF_LEN && !(p_wen_i && p_addr_i == OFF_LEN)
    |=> regs_q[4][1:0] == 2'b00 && regs_q[4][15:2] == $past(c_wdata_i[15:2]));
endmodule

// File: rtl/dreq_pingpong.sv
module dreq_pingpong
  import dreq_pkg::*;
#(
  parameter int unsigned WORDS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          data_avail_o,
  output logic          overflow_o,
  output logic          underrun_o
);
  localparam int unsigned IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  logic [DW-1:0] mem_q [2][WORDS];
  logic [1:0]    full_q, full_n;
  logic          wb_q, wb_n, rb_q, rb_n;
  logic [IW-1:0] wi_q, wi_n, ri_q, ri_n;
  logic          avail_n, ovf_n, und_n;
  logic          mem_we;
  logic          mem_blk;
  logic [IW-1:0] mem_idx;

  // read step first, then write step against the updated state
  always_comb begin
    full_n  = full_q;
    wb_n    = wb_q;
    rb_n    = rb_q;
    wi_n    = wi_q;
    ri_n    = ri_q;
    avail_n = 1'b0;
    ovf_n   = overflow_o;
    und_n   = underrun_o;
    mem_we  = 1'b0;
    mem_blk = wb_q;
    mem_idx = wi_q;

    if (pop_i) begin
      if (!full_q[rb_q]) und_n = 1'b1;
      if (ri_q == LAST) begin
        full_n[rb_q] = 1'b0;
        ri_n         = '0;
        if (full_n[~rb_q]) begin
          rb_n = ~rb_q;
          wb_n = rb_q;
        end
      end else begin
        ri_n = ri_q + 1'b1;
      end
    end

    if (push_i) begin
      if (full_n[wb_n]) begin
        ovf_n = 1'b1;
      end else begin
        mem_we  = 1'b1;
        mem_blk = wb_n;
        mem_idx = wi_q;
        if (wi_q == LAST) begin
          full_n[wb_n] = 1'b1;
          wi_n         = '0;
          if (!full_n[~wb_n]) begin
            rb_n    = wb_n;
            wb_n    = ~wb_n;
            avail_n = 1'b1;
          end
        end else begin
          wi_n = wi_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q       <= '0;
      wb_q         <= 1'b0;
      rb_q         <= 1'b0;
      wi_q         <= '0;
      ri_q         <= '0;
      data_avail_o <= 1'b0;
      overflow_o   <= 1'b0;
      underrun_o   <= 1'b0;
    end else begin
      full_q       <= full_n;
      wb_q         <= wb_n;
      rb_q         <= rb_n;
      wi_q         <= wi_n;
      ri_q         <= ri_n;
      data_avail_o <= avail_n;
      overflow_o   <= ovf_n;
      underrun_o   <= und_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < WORDS; w++)
          mem_q[b][w] <= '0;
    end else if (mem_we) begin
      mem_q[mem_blk][mem_idx] <= push_data_i;
    end
  end

  assign pop_data_o = mem_q[rb_q][ri_q];

  // R7
  avail_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_avail_o |-> full_q[rb_q] && !full_q[wb_q]);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  // R8
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && full_q[wb_q] |=> $stable(wi_q) && overflow_o);

  // R9
  und_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !full_q[rb_q] |=> underrun_o);

  // R10
  rd_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && ri_q == LAST && full_q[~rb_q] |=> rb_q != $past(rb_q) && wb_q == $past(rb_q));
endmodule

// File: rtl/dreq_fifo_window.sv
module dreq_fifo_window
  import dreq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        p_sel_i,
  input  logic        p_we_i,
  input  logic [2:0]  p_addr_i,
  input  logic [15:0] p_wdata_i,
  output logic [15:0] p_rdata_o,
  input  logic        c_sel_i,
  input  logic        c_we_i,
  input  logic [2:0]  c_addr_i,
  input  logic [15:0] c_wdata_i,
  output logic [15:0] c_rdata_o,
  output logic        data_avail_o,
  output logic        overflow_o,
  output logic        underrun_o
);
  logic          p_wen, c_wen, push, pop;
  logic [DW-1:0] p_reg_rd, c_reg_rd, fifo_word;

  assign p_wen = p_sel_i && p_we_i;
  assign c_wen = c_sel_i && c_we_i;
  assign push  = p_wen && p_addr_i == OFF_DATA;
  assign pop   = c_sel_i && !c_we_i && c_addr_i == OFF_DATA;

  dreq_cfg_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .p_wen_i   (p_wen),
    .p_addr_i  (p_addr_i),
    .p_wdata_i (p_wdata_i),
    .c_wen_i   (c_wen),
    .c_addr_i  (c_addr_i),
    .c_wdata_i (c_wdata_i),
    .p_rd_o    (p_reg_rd),
    .c_rd_o    (c_reg_rd)
  );

  dreq_pingpong #(.WORDS(4)) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_data_i  (p_wdata_i),
    .pop_i        (pop),
    .pop_data_o   (fifo_word),
    .data_avail_o (data_avail_o),
    .overflow_o   (overflow_o),
    .underrun_o   (underrun_o)
  );

  always_comb begin
    p_rdata_o = '0;
    if (p_sel_i && !p_we_i)
      p_rdata_o = (p_addr_i == OFF_DATA) ? PROD_DATA_RD : p_reg_rd;
  end

  always_comb begin
    c_rdata_o = '0;
    if (c_sel_i && !c_we_i)
      c_rdata_o = (c_addr_i == OFF_DATA) ? fifo_word : c_reg_rd;
  end

  // R4
  prod_data_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_sel_i && !p_we_i && p_addr_i == OFF_DATA && !pop && !c_wen
    |=> $stable(overflow_o) && $stable(underrun_o) && !data_avail_o);
endmodule

// File: tb/sim_dreq_fifo_window.sv
module sim_dreq_fifo_window;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        p_sel_i = 0, p_we_i = 0, c_sel_i = 0, c_we_i = 0;
  logic [2:0]  p_addr_i = 0, c_addr_i = 0;
  logic [15:0] p_wdata_i = 0, c_wdata_i = 0;
  logic [15:0] p_rdata_o, c_rdata_o;
  logic        data_avail_o, overflow_o, underrun_o;

  int errors = 0;
  int checks = 0;

  // reference state
  logic [15:0] m_reg [5];
  logic [15:0] m_mem [2][4];
  logic [1:0]  m_full;
  logic        m_wb, m_rb, m_pulse, m_ovf, m_und;
  int          m_wi, m_ri;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dreq_fifo_window u0 (.*);

  function automatic logic [15:0] mask_of(input int i);
    case (i)
      0: return 16'h00FF;
      1: return 16'hFFFE;
      2: return 16'h00FF;
      3: return 16'hFFFF;
      4: return 16'hFFFC;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 5; i++) m_reg[i] = '0;
    for (int b = 0; b < 2; b++) for (int w = 0; w < 4; w++) m_mem[b][w] = '0;
    m_full = '0; m_wb = 0; m_rb = 0; m_wi = 0; m_ri = 0;
    m_pulse = 0; m_ovf = 0; m_und = 0;
  endtask

  function automatic logic [15:0] exp_rd(input logic prod, input logic [2:0] a);
    if (a < 5) return m_reg[a];
    if (a == 5) return prod ? 16'hFFFF : m_mem[m_rb][m_ri];
    return 16'h0000;
  endfunction

  task automatic model_step(input logic ps, pw, input logic [2:0] pa, input logic [15:0] pd,
                            input logic cs, cw, input logic [2:0] ca, input logic [15:0] cd);
    logic push, pop;
    for (int i = 0; i < 5; i++) begin
      if (ps && pw && pa == 3'(i))      m_reg[i] = pd & mask_of(i);
      else if (cs && cw && ca == 3'(i)) m_reg[i] = cd & mask_of(i);
    end
    push = ps && pw && pa == 3'd5;
    pop  = cs && !cw && ca == 3'd5;
    m_pulse = 0;
    if (pop) begin
      if (!m_full[m_rb]) m_und = 1;
      m_ri++;
      if (m_ri == 4) begin
        m_full[m_rb] = 0; m_ri = 0;
        if (m_full[!m_rb]) begin m_wb = m_rb; m_rb = !m_rb; end
      end
    end
    if (push) begin
      if (m_full[m_wb]) m_ovf = 1;
      else begin
        m_mem[m_wb][m_wi] = pd;
        m_wi++;
        if (m_wi == 4) begin
          m_full[m_wb] = 1; m_wi = 0;
          if (!m_full[!m_wb]) begin m_rb = m_wb; m_wb = !m_wb; m_pulse = 1; end
        end
      end
    end
  endtask

  task automatic cyc(input string req,
                     input logic ps, pw, input logic [2:0] pa, input logic [15:0] pd,
                     input logic cs, cw, input logic [2:0] ca, input logic [15:0] cd);
    @(negedge clk_i);
    p_sel_i = ps; p_we_i = pw; p_addr_i = pa; p_wdata_i = pd;
    c_sel_i = cs; c_we_i = cw; c_addr_i = ca; c_wdata_i = cd;
    #1;
    if (ps && !pw) check({req, " prod rdata"}, p_rdata_o, exp_rd(1'b1, pa));
    if (cs && !cw) check({req, " cons rdata"}, c_rdata_o, exp_rd(1'b0, ca));
    @(posedge clk_i);
    model_step(ps, pw, pa, pd, cs, cw, ca, cd);
    #1;
    check({req, " data_avail"}, 16'(data_avail_o), 16'(m_pulse));
    check({req, " overflow"},   16'(overflow_o),   16'(m_ovf));
    check({req, " underrun"},   16'(underrun_o),   16'(m_und));
    @(negedge clk_i);
    p_sel_i = 0; p_we_i = 0; c_sel_i = 0; c_we_i = 0;
  endtask

  task automatic pwr(input string req, input logic [2:0] a, input logic [15:0] d);
    cyc(req, 1, 1, a, d, 0, 0, 0, 0);
  endtask
  task automatic crd(input string req, input logic [2:0] a);
    cyc(req, 0, 0, 0, 0, 1, 0, a, 0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();

    // R1 reset state from both ports
    for (int a = 0; a < 8; a++) cyc("R1", 1, 0, 3'(a), 0, 1, 0, 3'(a == 5 ? 0 : a), 0);

    // R2 R3 masking sweep, both directions
    for (int r = 0; r < 5; r++) begin
      for (int k = 0; k < 17; k++) begin
        logic [15:0] pat;
        pat = (k == 16) ? 16'hFFFF : 16'(1) << k;
        pwr("R2", 3'(r), pat);
        cyc("R3", 1, 0, 3'(r), 0, 1, 0, 3'(r), 0);
        cyc("R2", 0, 0, 0, 0, 1, 1, 3'(r), ~pat);
        cyc("R3", 1, 0, 3'(r), 0, 0, 0, 0, 0);
      end
    end

    // R3 unused offsets, collision on one register
    cyc("R3", 1, 1, 3'd6, 16'h1234, 1, 1, 3'd7, 16'h5678);
    for (int a = 0; a < 8; a++) cyc("R3", 1, 0, 3'(a), 0, 0, 0, 0, 0);
    cyc("R3", 1, 1, 3'd3, 16'hA5A5, 1, 1, 3'd3, 16'h5A5A);
    cyc("R3", 1, 0, 3'd3, 0, 1, 0, 3'd3, 0);

    // R6 R7 R10 streaming with producer data reads (R4) mixed in
    for (int round = 0; round < 5; round++) begin
      for (int w = 0; w < 4; w++) pwr("R7", 3'd5, 16'(round * 16'h1111 + w * 3 + 7));
      pwr("R4", 3'd5, 16'hBEEF);
      for (int w = 0; w < 2; w++) pwr("R6", 3'd5, 16'(16'hC000 + round * 8 + w));
      cyc("R4", 1, 0, 3'd5, 0, 0, 0, 0, 0);
      for (int w = 0; w < 4; w++) crd("R6", 3'd5);
      pwr("R6", 3'd5, 16'h0F0F);
      for (int w = 0; w < 4; w++) crd("R10", 3'd5);
    end

    // R8 overflow, R5 consumer write ignored
    do_reset();
    for (int w = 0; w < 9; w++) pwr("R8", 3'd5, 16'(16'h8000 + w));
    cyc("R5", 0, 0, 0, 0, 1, 1, 3'd5, 16'hDEAD);
    for (int w = 0; w < 8; w++) crd("R10", 3'd5);
    pwr("R8", 3'd5, 16'h4444);

    // R9 underrun on empty block
    do_reset();
    crd("R9", 3'd5);
    crd("R9", 3'd5);
    for (int w = 0; w < 4; w++) pwr("R9", 3'd5, 16'(16'h9000 + w));
    for (int w = 0; w < 4; w++) crd("R9", 3'd5);

    // R11 coincident completion of fill and drain
    do_reset();
    for (int w = 0; w < 4; w++) pwr("R11", 3'd5, 16'(16'hA000 + w));
    for (int w = 0; w < 3; w++) pwr("R11", 3'd5, 16'(16'hB000 + w));
    for (int w = 0; w < 3; w++) crd("R11", 3'd5);
    cyc("R11", 1, 1, 3'd5, 16'hB003, 1, 0, 3'd5, 0);
    for (int w = 0; w < 4; w++) crd("R11", 3'd5);

    // R11 both blocks full, read frees one, write lands in it
    do_reset();
    for (int w = 0; w < 8; w++) pwr("R11", 3'd5, 16'(16'hC100 + w));
    for (int w = 0; w < 3; w++) crd("R11", 3'd5);
    cyc("R11", 1, 1, 3'd5, 16'hD000, 1, 0, 3'd5, 0);
    for (int w = 0; w < 8; w++) crd("R11", 3'd5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule